// File: doc/BRIEF.md
# Banked Data RAM Window Translator

This block sits between a small 8-bit CPU core and a unified 4 KB on-chip data RAM. The RAM is made of 256 bytes of core RAM and 3840 bytes of expanded RAM. Every cycle the core presents an access kind and an 8-bit address. One clock edge later the block returns a 12-bit physical RAM address and region flags.

The physical space places core RAM at 000h–0FFh and expanded RAM at 100h–FFFh. An expanded offset X therefore appears as physical address 100h + X.

The block holds three small configuration registers, written through a simple select/data port:
- The bank register carries a window enable and a 6-bit bank number. Together they redirect direct accesses to 40h–7Fh onto any 64-byte bank of the 4 KB space.
- The page register gives external-style indirect accesses a 256-byte page of expanded RAM.
- The control register gates whether the expanded RAM answers at all. External-style accesses that the expanded RAM does not claim are flagged for the external bus.

Top module: `bank_window_xlat`

## Requirements
- R1: After a synchronous reset the outputs are all low, the window enable is 0, the bank number is 1, the page is 0 and the expanded-RAM enable is 0. With these values an external-style access to address A reports `q_ext`=1 and `q_addr`=A.
- R2: Results are registered. An access presented at edge N is reported after edge N. An access in the same cycle as a register write is translated with the register values from before that write.
- R3: A direct access with address bit 7 set (80h–FFh, special-register space) gives `q_ram`=0, `q_xram`=0 and `q_ext`=0. A direct access to 00h–3Fh gives `q_ram`=1 and core address equal to the input address.
- R4: With the window enable at 0, a direct access to 40h–7Fh maps to the same core address.
- R5: With the window enable at 1 and bank B below 4, a direct access to 40h+k (k in 0..63) maps to core address B×64+k, with `q_xram`=0.
- R6: With the window enable at 1, bank B of 4 or more, and the expanded-RAM enable at 1, address 40h+k maps to 100h+(B−4)×64+k with `q_xram`=1. For example, bank register value 88h and direct address 41h give expanded offset 0101h, which is physical 201h.
- R7: With the window enable at 1, bank B of 4 or more, and the expanded-RAM enable at 0, the window falls back to plain core RAM 40h–7Fh with `q_xram`=0.
- R8: An indirect-internal access to any address A maps to core address A with `q_ram`=1 and `q_xram`=0, whatever the configuration.
- R9: An external-style access with the expanded-RAM enable at 1 and page P in 0..14 maps to 100h+P×256+A, with `q_ram`=1 and `q_xram`=1.
- R10: An external-style access with the expanded-RAM enable at 0, or with page 15, gives `q_ram`=0 and `q_ext`=1, and `q_addr`={P,A} taken modulo 4096. `q_xram` and `q_ext` are never high together.
- R11: Register writes use `cfg_sel` as follows:
  - 0 selects the bank register: bit 7 is the window enable, bits 5:0 are the bank number, bit 6 is ignored.
  - 1 selects the page register: bits 3:0 are the page.
  - 2 selects the control register: bit 1 is the expanded-RAM enable.
  - 3 changes nothing.
  A register that is not selected keeps its value.
- R12: Access kind 3 (idle) gives all outputs low on the next cycle. The access kind encodings are 0 direct, 1 indirect-internal, 2 external-style and 3 idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_kind | input | 2 | Access kind: 0 direct, 1 indirect-internal, 2 external-style, 3 idle |
| acc_addr | input | 8 | CPU address of the access |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 bank, 1 page, 2 control |
| cfg_wdata | input | 8 | Register write data |
| q_ram | output | 1 | Access is served by the on-chip RAM |
| q_xram | output | 1 | Access lands in the expanded region |
| q_ext | output | 1 | External-style access left to the external bus |
| q_addr | output | 12 | Unified physical address, or the external address when `q_ext` is set |

## Verification
The bench sweeps every direct address for every bank number, under all four combinations of window enable and expanded-RAM enable. It also sweeps every page and address for external-style accesses.

The sweep targets the following corner cases and the fault each one exposes:
- Banks 0–3 against bank 4. A design that forgot to subtract four would shift all expanded banks by 256 bytes.
- Addresses 3Fh and 80h at the window edges. A loose window decode would remap them.
- Page 15. A design that claimed it would alias onto core RAM instead of raising `q_ext`.
- A register write in the same cycle as an access. A design that bypassed the new value would translate that access early.

Writes with bit 6 set, and writes to select 3, confirm that ignored fields leave the mapping untouched.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_XPAGE    = 2'd2,
    ACC_IDLE     = 2'd3
  } acc_kind_e;

  localparam logic [1:0] SEL_BANK = 2'd0;
  localparam logic [1:0] SEL_PAGE = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef struct packed {
    logic ram;
    logic xram;
    logic ext;
  } xlat_flags_t;

endpackage

// File: rtl/bwx_cfg_regs.sv
module bwx_cfg_regs
  import bwx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 6,
  parameter int PAGE_W  = 4,
  parameter int XEN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              win_en,
  output logic [BANK_W-1:0] bank_sel,
  output logic [PAGE_W-1:0] page_sel,
  output logic              xram_en
);

  localparam int EN_BIT = DATA_W - 1;
  localparam logic [BANK_W-1:0] BANK_RST = BANK_W'(1);

  logic unused_bits;
  assign unused_bits = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en   <= 1'b0;
      bank_sel <= BANK_RST;
      page_sel <= '0;
      xram_en  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_BANK: begin
          win_en   <= cfg_wdata[EN_BIT];
          bank_sel <= cfg_wdata[BANK_W-1:0];
        end
        SEL_PAGE: page_sel <= cfg_wdata[PAGE_W-1:0];
        SEL_CTRL: xram_en  <= cfg_wdata[XEN_BIT];
        default:  ;
      endcase
    end
  end

  // R11: registers that are not selected hold their values
  p_bank_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_sel == SEL_BANK) |=> ($stable(bank_sel) && $stable(win_en)));
  p_page_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_sel == SEL_PAGE) |=> $stable(page_sel));
  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_sel == SEL_CTRL) |=> $stable(xram_en));

endmodule

// File: rtl/bwx_window_map.sv
module bwx_window_map #(
  parameter int                ADDR_W     = 8,
  parameter int                WIN_W      = 6,
  parameter int                PHYS_W     = 12,
  parameter int                BANK_W     = 6,
  parameter int                CORE_BYTES = 256,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 8'h40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              win_en,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              xram_en,
  output logic              in_win,
  output logic [PHYS_W-1:0] map_addr,
  output logic              map_xram
);

  localparam int               CORE_BANKS   = CORE_BYTES >> WIN_W;
  localparam logic [BANK_W:0]  CORE_BANKS_V = (BANK_W+1)'(CORE_BANKS);
  localparam logic [PHYS_W-1:0] CORE_BASE   = PHYS_W'(CORE_BYTES);
  localparam logic [PHYS_W-1:0] BANK_SKEW   = PHYS_W'(CORE_BANKS);

  logic [WIN_W-1:0] off;
  logic             core_bank;

  assign off       = addr[WIN_W-1:0];
  assign in_win    = (addr[ADDR_W-1:WIN_W] == WIN_BASE[ADDR_W-1:WIN_W]);
  assign core_bank = ({1'b0, bank_sel} < CORE_BANKS_V);

  always_comb begin
    map_addr = PHYS_W'(addr);
    map_xram = 1'b0;
    if (in_win && win_en) begin
      if (core_bank) begin
        map_addr = (PHYS_W'(bank_sel) << WIN_W) | PHYS_W'(off);
      end else if (xram_en) begin
        map_addr = CORE_BASE + ((PHYS_W'(bank_sel) - BANK_SKEW) << WIN_W) + PHYS_W'(off);
        map_xram = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bwx_page_map.sv
module bwx_page_map #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_W     = 4,
  parameter int PHYS_W     = 12,
  parameter int CORE_BYTES = 256,
  parameter int XRAM_BYTES = 3840
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              xram_en,
  output logic              pg_hit,
  output logic [PHYS_W-1:0] pg_addr,
  output logic [PHYS_W-1:0] ext_addr
);

  localparam int                XRAM_PAGES   = XRAM_BYTES >> ADDR_W;
  localparam logic [PAGE_W:0]   XRAM_PAGES_V = (PAGE_W+1)'(XRAM_PAGES);
  localparam logic [PHYS_W-1:0] CORE_BASE    = PHYS_W'(CORE_BYTES);

  assign pg_hit   = xram_en && ({1'b0, page_sel} < XRAM_PAGES_V);
  assign pg_addr  = CORE_BASE + (PHYS_W'(page_sel) << ADDR_W) + PHYS_W'(addr);
  assign ext_addr = PHYS_W'({page_sel, addr});

endmodule

// File: rtl/bank_window_xlat.sv
module bank_window_xlat
  import bwx_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter int                PHYS_W     = 12,
  parameter int                BANK_W     = 6,
  parameter int                PAGE_W     = 4,
  parameter int                WIN_W      = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 8'h40,
  parameter int                CORE_BYTES = 256,
  parameter int                XRAM_BYTES = 3840
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              q_ram,
  output logic              q_xram,
  output logic              q_ext,
  output logic [PHYS_W-1:0] q_addr
);

  localparam logic [PHYS_W-1:0] CORE_LIMIT = PHYS_W'(CORE_BYTES);

  logic              win_en, xram_en;
  logic [BANK_W-1:0] bank_sel;
  logic [PAGE_W-1:0] page_sel;
  logic              in_win, map_xram, pg_hit;
  logic [PHYS_W-1:0] map_addr, pg_addr, ext_addr;

  xlat_flags_t       nxt_f;
  logic [PHYS_W-1:0] nxt_addr;
  acc_kind_e         kind;

  assign kind = acc_kind_e'(acc_kind);

  bwx_cfg_regs #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W), .XEN_BIT(1)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .win_en(win_en), .bank_sel(bank_sel), .page_sel(page_sel), .xram_en(xram_en)
  );

  bwx_window_map #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .PHYS_W(PHYS_W), .BANK_W(BANK_W),
    .CORE_BYTES(CORE_BYTES), .WIN_BASE(WIN_BASE)
  ) u_win (
    .addr(acc_addr), .win_en(win_en), .bank_sel(bank_sel), .xram_en(xram_en),
    .in_win(in_win), .map_addr(map_addr), .map_xram(map_xram)
  );

  bwx_page_map #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PHYS_W(PHYS_W),
    .CORE_BYTES(CORE_BYTES), .XRAM_BYTES(XRAM_BYTES)
  ) u_page (
    .addr(acc_addr), .page_sel(page_sel), .xram_en(xram_en),
    .pg_hit(pg_hit), .pg_addr(pg_addr), .ext_addr(ext_addr)
  );

  logic unused_win;
  assign unused_win = in_win;

  always_comb begin
    nxt_f    = '0;
    nxt_addr = '0;
    case (kind)
      ACC_DIRECT: begin
        if (!acc_addr[ADDR_W-1]) begin
          nxt_f.ram  = 1'b1;
          nxt_f.xram = map_xram;
          nxt_addr   = map_addr;
        end
      end
      ACC_INDIRECT: begin
        nxt_f.ram = 1'b1;
        nxt_addr  = PHYS_W'(acc_addr);
      end
      ACC_XPAGE: begin
        if (pg_hit) begin
          nxt_f.ram  = 1'b1;
          nxt_f.xram = 1'b1;
          nxt_addr   = pg_addr;
        end else begin
          nxt_f.ext = 1'b1;
          nxt_addr  = ext_addr;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_ram  <= 1'b0;
      q_xram <= 1'b0;
      q_ext  <= 1'b0;
      q_addr <= '0;
    end else begin
      q_ram  <= nxt_f.ram;
      q_xram <= nxt_f.xram;
      q_ext  <= nxt_f.ext;
      q_addr <= nxt_addr;
    end
  end

  // R10: expanded hit and external hand-off are exclusive
  p_xram_not_ext_r10: assert property (@(posedge clk) disable iff (rst)
    q_xram |-> !q_ext);
  // R6: expanded hits always sit above core RAM
  p_xram_region_r6: assert property (@(posedge clk) disable iff (rst)
    q_xram |-> (q_ram && q_addr >= CORE_LIMIT));
  // R5: core hits stay inside core RAM
  p_core_region_r5: assert property (@(posedge clk) disable iff (rst)
    (q_ram && !q_xram) |-> (q_addr < CORE_LIMIT));
  // R12: idle cycles leave outputs low
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'd3) |=> (!q_ram && !q_xram && !q_ext));
  // R3: special-register space is not RAM
  p_sfr_skip_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'd0 && acc_addr[ADDR_W-1]) |=> (!q_ram && !q_ext));
  // R8: indirect-internal is an identity core access
  p_indirect_core_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'd1) |=> (q_ram && !q_xram && q_addr[ADDR_W-1:0] == $past(acc_addr)));
  // R9: external-style accesses keep the low address byte
  p_xpage_low_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'd2) |=> ((q_ext || q_xram) && q_addr[ADDR_W-1:0] == $past(acc_addr)));

endmodule

// File: tb/sim_bank_window_xlat.sv
module sim_bank_window_xlat;
  import bwx_pkg::*;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  acc_kind;
  logic [7:0]  acc_addr;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        q_ram, q_xram, q_ext;
  logic [11:0] q_addr;

  bank_window_xlat u0 (
    .clk(clk), .rst(rst), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .q_ram(q_ram), .q_xram(q_xram), .q_ext(q_ext), .q_addr(q_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int m_bse = 0, m_bs = 1, m_xen = 0, m_pg = 0;

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > WATCHDOG_CYCLES) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // {ram, xram, ext, addr[11:0]}
  function automatic logic [14:0] model(int k, int a);
    logic [14:0] r;
    r = '0;
    case (k)
      0: begin
        if (a < 128) begin
          r[14] = 1'b1;
          r[11:0] = 12'(a);
          if (a >= 64 && m_bse != 0) begin
            if (m_bs < 4) r[11:0] = 12'(m_bs * 64 + a % 64);
            else if (m_xen != 0) begin
              r[11:0] = 12'(256 + (m_bs - 4) * 64 + a % 64);
              r[13] = 1'b1;
            end
          end
        end
      end
      1: begin
        r[14] = 1'b1;
        r[11:0] = 12'(a);
      end
      2: begin
        if (m_xen != 0 && m_pg < 15) begin
          r[14] = 1'b1; r[13] = 1'b1;
          r[11:0] = 12'(256 + m_pg * 256 + a);
        end else begin
          r[12] = 1'b1;
          r[11:0] = 12'((m_pg * 256 + a) % 4096);
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string direct_tag(int a);
    if (a >= 128 || a < 64) return "R3";
    if (m_bse == 0) return "R4";
    if (m_bs < 4) return "R5";
    if (m_xen != 0) return "R6";
    return "R7";
  endfunction

  task automatic compare(string tag, logic [14:0] exp);
    logic [14:0] got;
    got = {q_ram, q_xram, q_ext, q_addr};
    n_cmp = n_cmp + 1;
    if (got !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual ram=%b xram=%b ext=%b addr=%03h expected ram=%b xram=%b ext=%b addr=%03h",
               tag, got[14], got[13], got[12], got[11:0], exp[14], exp[13], exp[12], exp[11:0]);
    end
  endtask

  task automatic access(int k, int a, string tag);
    acc_kind = 2'(k);
    acc_addr = 8'(a);
    @(negedge clk);
    compare(tag, model(k, a));
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; acc_kind = 2'd3;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: begin m_bse = int'(d[7]); m_bs = int'(d[5:0]); end
      2'd1: m_pg = int'(d[3:0]);
      2'd2: m_xen = int'(d[1]);
      default: ;
    endcase
    compare("R12", 15'h0);
  endtask

  initial begin
    rst = 1'b1; acc_kind = 2'd3; acc_addr = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    compare("R1", 15'h0);
    rst = 1'b0;
    // R1: reset configuration seen through the mapping
    access(2, 8'h37, "R1");
    access(0, 8'h41, "R1");
    access(1, 8'h9A, "R8");

    // R6: documented example, bank 88h then direct 41h
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h88);
    access(0, 8'h41, "R6");
    compare("R6", {3'b110, 12'h201});

    // R2: write and access in the same cycle use old registers
    wr(2'd0, 8'h01);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h84;
    acc_kind = 2'd0; acc_addr = 8'h45;
    @(negedge clk);
    cfg_we = 1'b0;
    compare("R2", {3'b100, 12'h045});
    m_bse = 1; m_bs = 4;
    access(0, 8'h45, "R2");
    compare("R2", {3'b110, 12'h105});

    // R11: select 3 ignored, bit 6 ignored, control bit 1 only
    wr(2'd3, 8'hFF);
    access(0, 8'h45, "R11");
    compare("R11", {3'b110, 12'h105});
    wr(2'd0, 8'hC5);
    access(0, 8'h40, "R11");
    compare("R11", {3'b110, 12'h140});
    wr(2'd2, 8'hFD);
    access(0, 8'h40, "R7");
    compare("R7", {3'b100, 12'h040});
    wr(2'd1, 8'hF3);
    wr(2'd2, 8'h02);
    access(2, 8'h10, "R9");
    compare("R9", {3'b110, 12'h410});
    access(3, 8'h10, "R12");

    // Exhaustive direct sweep: R3 R4 R5 R6 R7
    for (int x = 0; x < 2; x++) begin
      wr(2'd2, 8'(x << 1));
      for (int e = 0; e < 2; e++) begin
        for (int b = 0; b < 64; b++) begin
          wr(2'd0, 8'((e << 7) | b));
          for (int a = 0; a < 256; a++) access(0, a, direct_tag(a));
        end
      end
    end

    // R8: indirect-internal ignores the configuration
    wr(2'd0, 8'h8A);
    for (int a = 0; a < 256; a++) access(1, a, "R8");

    // External-style sweep: R9 R10
    for (int x = 0; x < 2; x++) begin
      wr(2'd2, 8'(x << 1));
      for (int p = 0; p < 16; p++) begin
        wr(2'd1, 8'(p));
        for (int a = 0; a < 256; a++)
          access(2, a, (x != 0 && p < 15) ? "R9" : "R10");
      end
    end

    access(3, 8'h00, "R12");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule